// File: doc/BRIEF.md
# Word-Clock Rate Range Checker

This block measures the rate of an external word clock against a precise reference clock and decides whether that rate is one of six standard audio sample rates. The word clock is asynchronous to the reference. It is brought into the reference domain through a two-flop synchronizer, and its rising edges are counted over a window of a fixed number of reference cycles. At the end of each window the edge count is compared with a pair of count limits per nominal rate. These limits are computed at elaboration from the reference frequency, the window length and the tolerance in ppm.

The results are registered at the end of each window and hold until the next window ends. They are:
- an in-range flag,
- a range-error flag,
- a 3-bit rate index,
- a coarse-select output.

The coarse-select output tells the downstream clocking that the fast wide-range first stage must keep supplying the sample clock. Under that condition the fine stage must not be used. A missing input gives zero counted edges and is reported as a range error.

Top module: `wc_range_check`

## Requirements
- R1: Each rising edge of `wclk_in` that is seen in the reference domain is counted exactly once. The input passes through two synchronizer flops, and then one further flop is used for edge detection.
- R2: A window is exactly `WIN_CYCLES` reference cycles long. The first window ends on the `WIN_CYCLES`-th rising edge of `clk_ref` after reset is released. `rate_ok`, `rate_err`, `rate_idx` and `coarse_sel` change only on the edge that closes a window.
- R3: `rate_idx` identifies the matched rate as follows: 0 = 44.1 kHz, 1 = 48 kHz, 2 = 88.2 kHz, 3 = 96 kHz, 4 = 176.4 kHz, 5 = 192 kHz. When no rate matches, `rate_idx` is 7. Values 6 and 7 never appear together with `rate_ok`.
- R4: A window count N matches rate F when N lies between ceil(F·W·(1e6−PPM)/(REF_HZ·1e6)) and floor(F·W·(1e6+PPM)/(REF_HZ·1e6)) inclusive. A match sets `rate_ok`=1. If several rates match, the lowest index wins.
- R5: A non-zero count that matches no rate sets `rate_err`=1, `rate_ok`=0 and `rate_idx`=7.
- R6: A window with zero edges, such as a word clock held low, reports `rate_err`=1 and `rate_idx`=7.
- R7: `coarse_sel` is 1 whenever `rate_ok` is 0, including during a range error. It is 0 only while a rate is matched.
- R8: After reset and before the first window closes, the outputs are `rate_ok`=0, `rate_err`=0, `rate_idx`=7 and `coarse_sel`=1.
- R9: `rate_ok` and `rate_err` are never both 1. After the first window, exactly one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock of known frequency `REF_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk_in | input | 1 | External word clock, asynchronous to `clk_ref` |
| rate_ok | output | 1 | The last window matched a nominal rate |
| rate_err | output | 1 | The last window matched no nominal rate, or had no edges |
| rate_idx | output | 3 | Index of the matched rate, 0 to 5; 7 means no match |
| coarse_sel | output | 1 | Keep the wide-range first stage as the clock source; do not use the fine stage |

## Verification
The word clock is driven at each of the six nominal rates, so each index and its count band is exercised once. The patterns that separate 44.1 kHz from 48 kHz and 88.2 kHz from 96 kHz show that neighbouring bands do not overlap. Off-nominal rates are also driven: one below the lowest band, one in the gap between the 48 kHz and 88.2 kHz bands, and one above the highest band. These show that counts outside every band raise the range error rather than snapping to a neighbour. A held-low input separates the zero-edge case from an ordinary mismatch. A behavioural per-cycle model that counts sampled edges also catches windows where the rate changes mid-window.

// File: rtl/wc_range_pkg.sv
package wc_range_pkg;

  localparam int          NUM_RATES = 6;
  localparam logic [2:0]  IDX_NONE  = 3'd7;
  localparam longint unsigned PPM_SCALE = 64'd1_000_000;

  // Nominal sample rates in Hz, in index order
  function automatic longint unsigned nominal_hz(input int i);
    case (i)
      0:       nominal_hz = 64'd44_100;
      1:       nominal_hz = 64'd48_000;
      2:       nominal_hz = 64'd88_200;
      3:       nominal_hz = 64'd96_000;
      4:       nominal_hz = 64'd176_400;
      default: nominal_hz = 64'd192_000;
    endcase
  endfunction

  // Smallest acceptable edge count: ceil(F*W*(1e6-ppm) / (ref*1e6))
  function automatic longint unsigned count_lo(input longint unsigned f_hz,
                                               input longint unsigned ref_hz,
                                               input longint unsigned win,
                                               input longint unsigned ppm);
    longint unsigned num, den;
    num = f_hz * win * (PPM_SCALE - ppm);
    den = ref_hz * PPM_SCALE;
    count_lo = (num + den - 64'd1) / den;
  endfunction

  // Largest acceptable edge count: floor(F*W*(1e6+ppm) / (ref*1e6))
  function automatic longint unsigned count_hi(input longint unsigned f_hz,
                                               input longint unsigned ref_hz,
                                               input longint unsigned win,
                                               input longint unsigned ppm);
    longint unsigned num, den;
    num = f_hz * win * (PPM_SCALE + ppm);
    den = ref_hz * PPM_SCALE;
    count_hi = num / den;
  endfunction

endpackage

// File: rtl/wc_edge_sync.sv
module wc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic meta_q, stab_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  assign rise = stab_q & ~prev_q;
endmodule

// File: rtl/wc_meas_window.sv
module wc_meas_window #(
  parameter int WIN_CYCLES = 33_554_432,
  parameter int CNT_W      = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  output logic             win_end,
  output logic [CNT_W-1:0] win_total
);
  localparam int WIN_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_CYCLES - 1);

  logic [WIN_W-1:0] tick_q;
  logic [CNT_W-1:0] acc_q;

  assign win_end   = (tick_q == LAST);
  assign win_total = acc_q + {{(CNT_W-1){1'b0}}, edge_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      acc_q  <= '0;
    end else if (win_end) begin
      tick_q <= '0;
      acc_q  <= '0;
    end else begin
      tick_q <= tick_q + 1'b1;
      acc_q  <= win_total;
    end
  end
endmodule

// File: rtl/wc_rate_match.sv
module wc_rate_match
  import wc_range_pkg::*;
#(
  parameter longint unsigned REF_HZ     = 24_576_000,
  parameter int              WIN_CYCLES = 33_554_432,
  parameter int              PPM        = 100,
  parameter int              CNT_W      = 25
) (
  input  logic [CNT_W-1:0] count,
  output logic             hit_any,
  output logic [2:0]       hit_idx
);
  logic [NUM_RATES-1:0] hit;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_band
    localparam longint unsigned LO_L = count_lo(nominal_hz(g), REF_HZ,
                                                longint'(WIN_CYCLES), longint'(PPM));
    localparam longint unsigned HI_L = count_hi(nominal_hz(g), REF_HZ,
                                                longint'(WIN_CYCLES), longint'(PPM));
    localparam logic [CNT_W-1:0] LO = CNT_W'(LO_L);
    localparam logic [CNT_W-1:0] HI = CNT_W'(HI_L);
    assign hit[g] = (count != '0) && (count >= LO) && (count <= HI);
  end

  // Lowest index takes priority when bands overlap
  always_comb begin
    hit_idx = IDX_NONE;
    for (int i = NUM_RATES - 1; i >= 0; i--) begin
      if (hit[i]) hit_idx = 3'(i);
    end
  end

  assign hit_any = |hit;
endmodule

// File: rtl/wc_range_check.sv
module wc_range_check
  import wc_range_pkg::*;
#(
  parameter longint unsigned REF_HZ     = 24_576_000,
  parameter int              WIN_CYCLES = 33_554_432,
  parameter int              PPM        = 100
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       wclk_in,
  output logic       rate_ok,
  output logic       rate_err,
  output logic [2:0] rate_idx,
  output logic       coarse_sel
);
  // At most one edge every two reference cycles survives synchronization
  localparam int CNT_W = $clog2(WIN_CYCLES / 2 + 2);

  logic             edge_seen;
  logic             win_end;
  logic [CNT_W-1:0] win_total;
  logic             hit_any;
  logic [2:0]       hit_idx;

  wc_edge_sync u_sync (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .async_in (wclk_in),
    .rise     (edge_seen)
  );

  wc_meas_window #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_win (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .edge_i    (edge_seen),
    .win_end   (win_end),
    .win_total (win_total)
  );

  wc_rate_match #(.REF_HZ(REF_HZ), .WIN_CYCLES(WIN_CYCLES), .PPM(PPM), .CNT_W(CNT_W)) u_match (
    .count   (win_total),
    .hit_any (hit_any),
    .hit_idx (hit_idx)
  );

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      rate_ok    <= 1'b0;
      rate_err   <= 1'b0;
      rate_idx   <= IDX_NONE;
      coarse_sel <= 1'b1;
    end else if (win_end) begin
      rate_ok    <= hit_any;
      rate_err   <= ~hit_any;
      rate_idx   <= hit_idx;
      coarse_sel <= ~hit_any;
    end
  end
endmodule

// File: rtl/wc_range_check_chk.sv
module wc_range_check_chk #(
  parameter int CNT_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rate_ok,
  input logic             rate_err,
  input logic [2:0]       rate_idx,
  input logic             coarse_sel,
  input logic             win_end,
  input logic [CNT_W-1:0] win_total
);
  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rate_ok && rate_err));

  // R5
  err_idx_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_err |-> (rate_idx == 3'd7));

  // R3
  ok_idx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_ok |-> (rate_idx <= 3'd5));

  // R7
  err_forces_coarse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_err |-> coarse_sel);

  // R7
  fine_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_sel |-> rate_ok);

  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(win_end) |-> ($stable(rate_idx) && $stable(rate_ok) &&
                         $stable(rate_err) && $stable(coarse_sel)));

  // R6
  zero_edges_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && (win_total == '0)) |=> (rate_err && rate_idx == 3'd7));

  // R9
  decided_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (rate_ok != rate_err));
endmodule

bind wc_range_check wc_range_check_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk_ref),
  .rst_n      (rst_n),
  .rate_ok    (rate_ok),
  .rate_err   (rate_err),
  .rate_idx   (rate_idx),
  .coarse_sel (coarse_sel),
  .win_end    (win_end),
  .win_total  (win_total)
);

// File: tb/sim_wc_range_check.sv
`timescale 1ns/1ps
module sim_wc_range_check;
  localparam real     CLK_PERIOD = 100.0;
  localparam longint  REF_HZ     = 10_000_000;
  localparam int      WIN        = 8000;
  localparam int      PPM        = 40000;

  logic       clk_ref = 1'b0;
  logic       rst_n   = 1'b0;
  logic       wclk_in = 1'b0;
  logic       rate_ok, rate_err, coarse_sel;
  logic [2:0] rate_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  real wc_hz = 0.0;
  real phase = 0.0;

  wc_range_check #(.REF_HZ(REF_HZ), .WIN_CYCLES(WIN), .PPM(PPM)) u0 (
    .clk_ref(clk_ref), .rst_n(rst_n), .wclk_in(wclk_in),
    .rate_ok(rate_ok), .rate_err(rate_err), .rate_idx(rate_idx), .coarse_sel(coarse_sel)
  );

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  // Word clock: toggles on reference negedges from a phase accumulator
  always @(negedge clk_ref) begin
    if (wc_hz == 0.0) begin
      wclk_in = 1'b0;
      phase   = 0.0;
    end else begin
      phase = phase + 2.0 * wc_hz * CLK_PERIOD * 1.0e-9;
      if (phase >= 1.0) begin
        phase   = phase - 1.0;
        wclk_in = ~wclk_in;
      end
    end
  end

  // Behavioural reference model
  function automatic int classify(input int n);
    real rates[6] = '{44100.0, 48000.0, 88200.0, 96000.0, 176400.0, 192000.0};
    classify = 7;
    if (n == 0) return 7;
    for (int k = 0; k < 6; k++) begin
      real ideal, slack;
      ideal = rates[k] * WIN / REF_HZ;
      slack = ideal * PPM / 1.0e6;
      if ($itor(n) >= ideal - slack && $itor(n) <= ideal + slack) return k;
    end
  endfunction

  bit samp[$];
  int m_tick = 0, m_cnt = 0, m_idx = 7;
  bit m_ok = 0, m_err = 0, m_coarse = 1;

  always @(posedge clk_ref) begin
    if (!rst_n) begin
      samp = '{1'b0, 1'b0, 1'b0};
      m_tick = 0; m_cnt = 0; m_idx = 7; m_ok = 0; m_err = 0; m_coarse = 1;
    end else begin
      int ev;
      ev = (samp[1] && !samp[2]) ? 1 : 0;
      if (m_tick == WIN - 1) begin
        m_idx = classify(m_cnt + ev);
        m_ok = (m_idx != 7); m_err = !m_ok; m_coarse = !m_ok;
        m_tick = 0; m_cnt = 0;
      end else begin
        m_tick++; m_cnt += ev;
      end
      samp.push_front(wclk_in);
      if (samp.size() > 3) void'(samp.pop_back());
    end
  end

  // Per-cycle comparison (R1, R2, R4)
  always @(negedge clk_ref) begin
    if (rst_n && !done) begin
      checks++;
      if (rate_ok !== m_ok || rate_err !== m_err || rate_idx !== 3'(m_idx) ||
          coarse_sel !== m_coarse) begin
        errors++;
        $display("FAIL R1/R2/R4 cycle model: got ok=%0b err=%0b idx=%0d coarse=%0b exp ok=%0b err=%0b idx=%0d coarse=%0b",
                 rate_ok, rate_err, rate_idx, coarse_sel, m_ok, m_err, m_idx, m_coarse);
      end
    end
  end

  task automatic expect_out(input string req, input bit ok, input bit err,
                            input int idx, input bit coarse);
    checks++;
    if (rate_ok !== ok || rate_err !== err || rate_idx !== 3'(idx) || coarse_sel !== coarse) begin
      errors++;
      $display("FAIL %s: got ok=%0b err=%0b idx=%0d coarse=%0b exp ok=%0b err=%0b idx=%0d coarse=%0b",
               req, rate_ok, rate_err, rate_idx, coarse_sel, ok, err, idx, coarse);
    end
  endtask

  task automatic segment(input real hz, input int idx, input string req);
    wc_hz = hz;
    repeat (2 * WIN) @(posedge clk_ref);
    #(CLK_PERIOD/4);
    if (idx == 7) expect_out(req, 1'b0, 1'b1, 7, 1'b1);
    else          expect_out(req, 1'b1, 1'b0, idx, 1'b0);
  endtask

  initial begin
    repeat (5) @(posedge clk_ref);
    #(CLK_PERIOD/4);
    expect_out("R8 reset state", 1'b0, 1'b0, 7, 1'b1);
    @(negedge clk_ref);
    rst_n = 1'b1;
    #(CLK_PERIOD/4);
    expect_out("R8 after release", 1'b0, 1'b0, 7, 1'b1);
    segment(48000.0,  1, "R3 R4 48k");
    segment(44100.0,  0, "R3 R4 44.1k");
    segment(192000.0, 5, "R3 R4 192k");
    segment(0.0,      7, "R6 no input");
    segment(40000.0,  7, "R5 below lowest band");
    segment(88200.0,  2, "R3 R4 88.2k");
    segment(60000.0,  7, "R5 R7 gap between bands");
    segment(96000.0,  3, "R3 R4 96k");
    segment(176400.0, 4, "R3 R4 176.4k");
    segment(250000.0, 7, "R5 R9 above highest band");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_ref);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule